// File: doc/BRIEF.md
# Alternating add-carry XOR checksum engine

This block computes a running checksum over a stream of 16-bit words for short datagrams. Its state is two accumulators, X and Y, and one carry bit. Each accepted word performs one half-step. The two half-steps alternate. In the first half-step, Y takes in X plus the carry, and X takes in the word by XOR. In the second half-step the two accumulators swap roles. Each addition writes its carry-out back into the carry bit, and the next addition reads it in.

A producer drives `start_i` for one cycle to clear the state. It then presents words with a valid/ready handshake, one per clock. The producer packs the first byte of each pair into bits 7:0, and it pads a message with an odd word count with one zero word. A combinational view gives the running result at all times, in two forms: a 32-bit concatenation and a 16-bit XOR fold. Pulsing `done_i` copies both forms into registered outputs and raises a one-cycle strobe.

A small state machine tracks the pair phase. Its states are `ST_PAIR_LO` (the next word is the first of a pair) and `ST_PAIR_HI` (the next word is the second). It has three transitions:

- `T_TAKE_FIRST` moves from `ST_PAIR_LO` to `ST_PAIR_HI` when a word is accepted.
- `T_TAKE_SECOND` moves from `ST_PAIR_HI` to `ST_PAIR_LO` when a word is accepted.
- `T_RESTART` goes from either state to `ST_PAIR_LO` on `start_i`.

With no accepted word and no start, the machine holds its state.

Top module: `altcsum_engine`

## Requirements
- R1: After reset X=0x0000, Y=0x0000, carry=0, the phase is first-word, `ready_o` is 1, `res_valid_o` is 0 and `sum32_o` reads 0.
- R2: A word accepted in the first-word phase sets Y to Y+X+carry (modulo 2^16) using the old X, and sets X to X XOR word.
- R3: A word accepted in the second-word phase sets X to X+Y+carry (modulo 2^16) using the old Y, and sets Y to Y XOR word.
- R4: Each addition stores its carry-out (bit 16 of the 17-bit sum) in the carry bit, and the next addition adds that bit in. The XOR updates leave the carry bit unchanged.
- R5: A word is accepted only when `valid_i` and `ready_o` are both 1. Cycles without acceptance leave X, Y, carry and the phase unchanged.
- R6: `start_i` drives `ready_o` low in that cycle. On the next edge it reloads X=0, Y=0, carry=0 and the first-word phase, whatever the phase was. A word offered during the start cycle is not taken.
- R7: `sum32_o` is {X, Y}, with X in bits 31:16, and `fold16_o` is X XOR Y. Both follow the state with no added latency.
- R8: `done_i` captures `sum32_o` into `res32_o` and `fold16_o` into `res16_o` at the next edge. `res_valid_o` is 1 for exactly that one following cycle. The captured values hold until the next `done_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle pulse that reinitialises the checksum |
| valid_i | input | 1 | Word present on `word_i` |
| word_i | input | 16 | Data word, first byte of the pair in bits 7:0 |
| ready_o | output | 1 | Engine can take a word this cycle |
| done_i | input | 1 | Capture the current result |
| sum32_o | output | 32 | Live result {X, Y} |
| fold16_o | output | 16 | Live result X XOR Y |
| res32_o | output | 32 | Captured 32-bit result |
| res16_o | output | 16 | Captured 16-bit result |
| res_valid_o | output | 1 | One-cycle strobe for a new capture |

## Verification
Because the result is a live view of the state, a wrong accumulator, a wrong carry or a wrong phase appears on `sum32_o` in the cycle right after the word that caused it. A carry or phase error may leave that first result unchanged and only show one word later, when the next addition uses it. The scoreboard therefore compares every accepted word against an independent model across long streams with idle gaps. A fixed hand-worked sequence forces carry-outs. Restarts in the middle of a pair check that the phase returns to the first-word state.

// File: rtl/altcsum_pkg.sv
package altcsum_pkg;

    // Pair phase of the checksum engine
    typedef enum logic [0:0] {
        ST_PAIR_LO = 1'b0,  // next accepted word is the first of a pair
        ST_PAIR_HI = 1'b1   // next accepted word is the second of a pair
    } pair_state_e;

    // Which update the datapath applies in a cycle
    typedef enum logic [1:0] {
        OP_HOLD   = 2'd0,
        OP_FIRST  = 2'd1,
        OP_SECOND = 2'd2,
        OP_CLEAR  = 2'd3
    } accum_op_e;

endpackage

// File: rtl/altcsum_ctrl.sv
module altcsum_ctrl
    import altcsum_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        valid_i,
    output logic        ready_o,
    output accum_op_e   op_o,
    output logic        first_phase_o
);

    pair_state_e state_q;
    pair_state_e state_d;
    logic        accept;

    assign ready_o = !start_i;
    assign accept  = valid_i && !start_i;

    // next-state logic and state register
    always_comb begin
        state_d = state_q;
        if (start_i) begin
            state_d = ST_PAIR_LO;                    // T_RESTART
        end else if (accept) begin
            unique case (state_q)
                ST_PAIR_LO: state_d = ST_PAIR_HI;    // T_TAKE_FIRST
                ST_PAIR_HI: state_d = ST_PAIR_LO;    // T_TAKE_SECOND
                default:    state_d = ST_PAIR_LO;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PAIR_LO;
        end else begin
            state_q <= state_d;
        end
    end

    // output decode
    always_comb begin
        op_o = OP_HOLD;
        if (start_i) begin
            op_o = OP_CLEAR;
        end else if (accept) begin
            unique case (state_q)
                ST_PAIR_LO: op_o = OP_FIRST;
                ST_PAIR_HI: op_o = OP_SECOND;
                default:    op_o = OP_HOLD;
            endcase
        end
    end

    assign first_phase_o = (state_q == ST_PAIR_LO);

endmodule

// File: rtl/altcsum_adc.sv
module altcsum_adc #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);

    localparam int SW = W + 1;

    logic [SW-1:0] wide;

    always_comb begin
        wide   = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
        sum_o  = wide[W-1:0];
        cout_o = wide[SW-1];
    end

endmodule

// File: rtl/altcsum_accum.sv
module altcsum_accum
    import altcsum_pkg::*;
#(
    parameter int          W      = 16,
    parameter logic [W-1:0] X_INIT = '0,
    parameter logic [W-1:0] Y_INIT = '0,
    parameter logic         C_INIT = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  accum_op_e    op_i,
    input  logic [W-1:0] word_i,
    output logic [W-1:0] x_o,
    output logic [W-1:0] y_o
);

    logic [W-1:0] x_q, y_q;
    logic         c_q;
    logic [W-1:0] x_d, y_d;
    logic         c_d;

    logic [W-1:0] add_sum;
    logic         add_cout;

    // a single shared adder: X+Y+carry is symmetric, so both half-steps reuse it
    altcsum_adc #(.W(W)) u_adc (
        .a_i   (x_q),
        .b_i   (y_q),
        .cin_i (c_q),
        .sum_o (add_sum),
        .cout_o(add_cout)
    );

    always_comb begin
        x_d = x_q;
        y_d = y_q;
        c_d = c_q;
        unique case (op_i)
            OP_HOLD: begin
            end
            OP_FIRST: begin
                y_d = add_sum;
                c_d = add_cout;
                x_d = x_q ^ word_i;
            end
            OP_SECOND: begin
                x_d = add_sum;
                c_d = add_cout;
                y_d = y_q ^ word_i;
            end
            OP_CLEAR: begin
                x_d = X_INIT;
                y_d = Y_INIT;
                c_d = C_INIT;
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_q <= X_INIT;
            y_q <= Y_INIT;
            c_q <= C_INIT;
        end else begin
            x_q <= x_d;
            y_q <= y_d;
            c_q <= c_d;
        end
    end

    assign x_o = x_q;
    assign y_o = y_q;

endmodule

// File: rtl/altcsum_capture.sv
module altcsum_capture #(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           done_i,
    input  logic [2*W-1:0] cat_i,
    input  logic [W-1:0]   fold_i,
    output logic [2*W-1:0] cat_o,
    output logic [W-1:0]   fold_o,
    output logic           strobe_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cat_o    <= '0;
            fold_o   <= '0;
            strobe_o <= 1'b0;
        end else begin
            strobe_o <= done_i;
            if (done_i) begin
                cat_o  <= cat_i;
                fold_o <= fold_i;
            end
        end
    end

endmodule

// File: rtl/altcsum_engine.sv
module altcsum_engine
    import altcsum_pkg::*;
#(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic           valid_i,
    input  logic [W-1:0]   word_i,
    output logic           ready_o,
    input  logic           done_i,
    output logic [2*W-1:0] sum32_o,
    output logic [W-1:0]   fold16_o,
    output logic [2*W-1:0] res32_o,
    output logic [W-1:0]   res16_o,
    output logic           res_valid_o
);

    accum_op_e    op;
    logic         in_first;
    logic [W-1:0] x_val, y_val;

    altcsum_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .valid_i      (valid_i),
        .ready_o      (ready_o),
        .op_o         (op),
        .first_phase_o(in_first)
    );

    altcsum_accum #(.W(W)) u_accum (
        .clk   (clk),
        .rst_n (rst_n),
        .op_i  (op),
        .word_i(word_i),
        .x_o   (x_val),
        .y_o   (y_val)
    );

    assign sum32_o  = {x_val, y_val};
    assign fold16_o = x_val ^ y_val;

    altcsum_capture #(.W(W)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .done_i  (done_i),
        .cat_i   (sum32_o),
        .fold_i  (fold16_o),
        .cat_o   (res32_o),
        .fold_o  (res16_o),
        .strobe_o(res_valid_o)
    );

endmodule

// File: rtl/altcsum_chk.sv
module altcsum_chk #(
    parameter int W = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start_i,
    input logic           valid_i,
    input logic [W-1:0]   word_i,
    input logic           ready_o,
    input logic           done_i,
    input logic           in_first,
    input logic [2*W-1:0] sum32_o,
    input logic [W-1:0]   fold16_o,
    input logic [2*W-1:0] res32_o,
    input logic           res_valid_o
);

    // R2
    first_xor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && ready_o && in_first) |=>
            (sum32_o[2*W-1:W] == ($past(sum32_o[2*W-1:W]) ^ $past(word_i))));

    // R3
    second_xor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && ready_o && !in_first) |=>
            (sum32_o[W-1:0] == ($past(sum32_o[W-1:0]) ^ $past(word_i))));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_i && !start_i) |=> $stable(sum32_o));

    // R6
    restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (sum32_o == '0 && in_first));

    // R8
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> (res_valid_o && res32_o == $past(sum32_o)));

    // R8
    strobe_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_i |=> !res_valid_o);

endmodule

bind altcsum_engine altcsum_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .valid_i    (valid_i),
    .word_i     (word_i),
    .ready_o    (ready_o),
    .done_i     (done_i),
    .in_first   (in_first),
    .sum32_o    (sum32_o),
    .fold16_o   (fold16_o),
    .res32_o    (res32_o),
    .res_valid_o(res_valid_o)
);

// File: tb/altcsum_engine_bench.sv
`timescale 1ns/1ps
module altcsum_engine_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        valid_i = 1'b0;
    logic [15:0] word_i = '0;
    logic        done_i = 1'b0;
    logic        ready_o;
    logic [31:0] sum32_o;
    logic [15:0] fold16_o;
    logic [31:0] res32_o;
    logic [15:0] res16_o;
    logic        res_valid_o;

    always #2.5 clk = ~clk;

    altcsum_engine u_altcsum_engine (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .valid_i(valid_i),
        .word_i(word_i), .ready_o(ready_o), .done_i(done_i),
        .sum32_o(sum32_o), .fold16_o(fold16_o), .res32_o(res32_o),
        .res16_o(res16_o), .res_valid_o(res_valid_o)
    );

    int tests = 0;
    int fails = 0;

    // reference model, built from the requirements
    logic [15:0] mx = '0, my = '0;
    logic        mc = 1'b0;
    logic        mfirst = 1'b1;
    logic [31:0] exp_q[$];

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_step(input logic [15:0] w);
        logic [16:0] s;
        if (mfirst) begin
            s  = {1'b0, my} + {1'b0, mx} + {16'b0, mc};
            my = s[15:0]; mc = s[16]; mx = mx ^ w;
        end else begin
            s  = {1'b0, mx} + {1'b0, my} + {16'b0, mc};
            mx = s[15:0]; mc = s[16]; my = my ^ w;
        end
        mfirst = !mfirst;
    endtask

    // driver: offers one word, updates the model, queues the expected state
    task automatic send_word(input logic [15:0] w);
        @(negedge clk);
        valid_i = 1'b1;
        word_i  = w;
        @(posedge clk);
        model_step(w);
        exp_q.push_back({mx, my});
        @(negedge clk);
        valid_i = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // monitor: compares each expected item with the live result (R2 R3 R4 R7)
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [31:0] e;
            e = exp_q.pop_front();
            check("R2/R3/R4 sum32_o", sum32_o, e);
            check("R7 fold16_o", {16'b0, fold16_o}, {16'b0, e[31:16] ^ e[15:0]});
        end
    end

    task automatic do_start(input logic offer);
        @(negedge clk);
        start_i = 1'b1;
        valid_i = offer;
        word_i  = 16'hDEAD;
        #0.5;
        check("R6 ready low in start cycle", {31'b0, ready_o}, 32'd0);
        @(negedge clk);
        start_i = 1'b0;
        valid_i = 1'b0;
        mx = '0; my = '0; mc = 1'b0; mfirst = 1'b1;
        check("R6 cleared, offered word not taken", sum32_o, 32'd0);
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        logic [31:0] held;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 sum32_o at reset", sum32_o, 32'd0);
        check("R1 ready_o at reset", {31'b0, ready_o}, 32'd1);
        check("R1 res_valid_o at reset", {31'b0, res_valid_o}, 32'd0);
        rst_n = 1'b1;
        idle(1);

        // hand-worked sequence with carries (R4)
        send_word(16'h1234);
        send_word(16'hABCD);
        send_word(16'hFFFF);
        send_word(16'h0001);
        send_word(16'h0000);
        idle(1);
        check("R4 fixed vector sum32_o", sum32_o, 32'hABCC69CD);
        check("R7 fixed vector fold16_o", {16'b0, fold16_o}, 32'h0000C201);

        // R5 idle cycles hold the state
        held = sum32_o;
        idle(4);
        check("R5 hold with valid low", sum32_o, held);

        // R8 capture
        @(negedge clk);
        done_i = 1'b1;
        @(negedge clk);
        done_i = 1'b0;
        check("R8 strobe", {31'b0, res_valid_o}, 32'd1);
        check("R8 res32_o", res32_o, held);
        check("R8 res16_o", {16'b0, res16_o}, {16'b0, held[31:16] ^ held[15:0]});
        send_word(16'h5A5A);
        idle(1);
        check("R8 strobe one cycle", {31'b0, res_valid_o}, 32'd0);
        check("R8 capture held", res32_o, held);

        // R6 restart with a word offered in the start cycle
        do_start(1'b1);
        // restart in the middle of a pair resets the phase
        send_word(16'h0F0F);
        do_start(1'b0);
        send_word(16'h1111);
        idle(1);
        check("R6 first phase after restart", sum32_o, 32'h11110000);

        // long stream with gaps (R2 R3 R4 R5)
        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            send_word(lfsr);
            if (lfsr[0]) idle(int'(lfsr[3:2]));
        end
        idle(2);
        check("R4 stream end state", sum32_o, {mx, my});

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule